// File: doc/BRIEF.md
# Transformer-Coupled Isolated Gate Driver

This block drives a bank of isolated switch outputs. Each switch is a MOSFET whose gate is fed through a small transformer and rectifier. A transformer passes no DC, so a switch that should be on needs a square-wave carrier on its line, not a steady high. Software programs two registers over a simple 32-bit word bus. The data register selects which outputs are on. The rate register holds a 12-bit divisor and an enable bit.

A down-counter divides the module clock to make one shared carrier. Each half-period of the carrier lasts the divisor plus two clocks, so the carrier frequency is the clock divided by (divisor + 2), then divided by 2. Outputs 0 to 30 each carry the carrier when their data bit is set. The top output lane never goes to a connector. It carries the bare carrier as a reference whenever the enable bit is set, whatever data bit 31 holds. While the enable bit is clear, every output stays low.

Top module: `iso_gate_driver`

## Requirements
- R1: The data register sits at word index 0. It stores all 32 written bits and reads them back unchanged.
- R2: Rate register bits 11:0 hold the divisor. While enabled, every output that is on stays high for exactly divisor+2 clocks and then low for divisor+2 clocks. This holds at both divisor extremes, 0x000 and 0xFFF.
- R3: Rate register bit 12 is the enable. While it is 0, all outputs are low, whatever the data register holds.
- R4: Each output i from 0 to 30 equals (data bit i AND enable AND carrier phase), taken through one output register. Changing the data register does not disturb the carrier timing.
- R5: Output 31 carries the carrier gated only by the enable. Data bit 31 has no effect on any output.
- R6: A write to the rate register at clock edge W restarts the carrier. Outputs are low from edge W+1 through edge W+divisor+2. From edge W+divisor+3 they follow the carrier for the new divisor.
- R7: A synchronous active-low reset clears both registers, the read data, the counter and all outputs to zero.
- R8: The rate register sits at word index 1. It reads back bits 12:0 as written, and bits 31:13 read as zero.
- R9: A read returns its value on bus_rdata one clock after the bus_rd cycle. Word indices other than 0 and 1 read as zero, and writes to them change nothing.
- R10: Writing all zeros to the rate register stops all drive, including the reference lane. The data register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per word |
| bus_rd | input | 1 | Read strobe, one cycle per word |
| bus_addr | input | 4 | Word index (0 data, 1 rate) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| gate_drive | output | 32 | Carrier-gated drive lanes; lane 31 is the reference |

## Verification
The carrier is checked cycle by cycle against a model built from the rules above. The data patterns used are all user bits set, an alternating nibble pattern, alternate bits, and only bit 31 set. Together they show whether each lane is gated by its own bit and whether the reference lane ignores data. Divisors 0, 3, 5 and 0xFFF separate an off-by-one in the half-period from a wrong reload. A rate write in the middle of a phase shows whether the carrier restarts low. A data write while the carrier runs shows that data changes leave the carrier timing alone. Unmapped writes, an all-zero rate write and a reset in mid-run each check that state is kept or cleared as the requirements say.

// File: rtl/iso_gate_pkg.sv
// Package: shared constants for the isolated gate driver.
// Assumes one enable bit placed directly above the divisor field.
package iso_gate_pkg;
    localparam int DIV_W    = 12;  // divisor field width; enable sits at bit DIV_W
    localparam int REG_DATA = 0;   // word index of the output data register
    localparam int REG_RATE = 1;   // word index of the rate/enable register
endpackage

// File: rtl/iso_gate_regs.sv
// Module: register file and bus decode.
// Holds the data and rate registers, produces a one-cycle restart pulse on
// any rate write, and returns registered read data one clock after a read.
// Assumes at most one of bus_wr/bus_rd per cycle is meaningful per word.
module iso_gate_regs #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter int DIV_W  = iso_gate_pkg::DIV_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] data_q,
    output logic [DIV_W-1:0]  div_q,
    output logic              en_q,
    output logic              restart,
    output logic [DIV_W-1:0]  div_next
);
    localparam int RATE_W = DIV_W + 1;

    logic hit_data;
    logic hit_rate;
    logic [DATA_W-1:0] rd_mux;

    // Address decode for the two mapped words.
    always_comb begin
        hit_data = (bus_addr == ADDR_W'(iso_gate_pkg::REG_DATA));
        hit_rate = (bus_addr == ADDR_W'(iso_gate_pkg::REG_RATE));
        restart  = bus_wr && hit_rate;
        div_next = bus_wdata[DIV_W-1:0];
    end

    // Data register update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            data_q <= '0;
        else if (bus_wr && hit_data)
            data_q <= bus_wdata;
    end

    // Rate register update: divisor and enable only; upper bits dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            en_q  <= 1'b0;
        end else if (restart) begin
            div_q <= bus_wdata[DIV_W-1:0];
            en_q  <= bus_wdata[DIV_W];
        end
    end

    // Read source select; unmapped words read as zero.
    always_comb begin
        if (hit_data)
            rd_mux = data_q;
        else if (hit_rate)
            rd_mux = DATA_W'({en_q, div_q});
        else
            rd_mux = '0;
    end

    // Read data register, loaded only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= rd_mux;
    end

    // Width sanity for the packed rate readback.
    initial begin
        if (RATE_W > DATA_W) $display("iso_gate_regs: rate field wider than bus");
    end
endmodule

// File: rtl/iso_gate_carrier.sv
// Module: carrier generator.
// A down-counter reloads with divisor+1 and toggles the phase flip-flop each
// time it reaches zero, so every half-period lasts divisor+2 clocks.
// A restart pulse reloads from the incoming divisor and forces phase low.
// Assumes the enable only changes together with a restart pulse.
module iso_gate_carrier #(
    parameter int DIV_W = iso_gate_pkg::DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div_q,
    input  logic             restart,
    input  logic [DIV_W-1:0] div_next,
    output logic             phase,
    output logic [DIV_W:0]   cnt_o
);
    localparam int CNT_W = DIV_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload_run;
    logic [CNT_W-1:0] reload_new;

    // Reload values: one less than the half-period length.
    always_comb begin
        reload_run = CNT_W'(div_q)    + CNT_W'(1);
        reload_new = CNT_W'(div_next) + CNT_W'(1);
    end

    // Counter and phase sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            phase <= 1'b0;
        end else if (restart) begin
            cnt_q <= reload_new;
            phase <= 1'b0;
        end else if (!en) begin
            phase <= 1'b0;
        end else if (cnt_q == '0) begin
            cnt_q <= reload_run;
            phase <= ~phase;
        end else begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/iso_gate_lanes.sv
// Module: per-lane gating and output registers.
// User lanes carry (data AND enable AND phase); the top lane carries the
// carrier gated by the enable only and serves as a reference.
// Assumes NUM_OUT >= 2.
module iso_gate_lanes #(
    parameter int NUM_OUT = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               phase,
    input  logic [NUM_OUT-2:0] user_on,
    output logic [NUM_OUT-1:0] drive
);
    logic live;

    // Shared carrier gate.
    always_comb live = en & phase;

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_lane
        if (g == NUM_OUT - 1) begin : g_ref
            // Reference lane register: carrier whenever enabled.
            always_ff @(posedge clk) begin
                if (!rst_n) drive[g] <= 1'b0;
                else        drive[g] <= live;
            end
        end else begin : g_user
            // User lane register: carrier gated by its data bit.
            always_ff @(posedge clk) begin
                if (!rst_n) drive[g] <= 1'b0;
                else        drive[g] <= live & user_on[g];
            end
        end
    end
endmodule

// File: rtl/iso_gate_driver.sv
// Module: top of the transformer-coupled isolated gate driver.
// Ties the register file, carrier generator and lane gating together.
// Assumes NUM_OUT <= DATA_W and a single clock domain.
module iso_gate_driver #(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 4,
    parameter int NUM_OUT = 32,
    parameter int DIV_W   = iso_gate_pkg::DIV_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_OUT-1:0] gate_drive
);
    logic [DATA_W-1:0] data_q;
    logic [DIV_W-1:0]  div_q;
    logic              rate_en;
    logic              rate_restart;
    logic [DIV_W-1:0]  div_next;
    logic              carrier_phase;
    logic [DIV_W:0]    carrier_cnt;

    iso_gate_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DIV_W(DIV_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .data_q(data_q), .div_q(div_q), .en_q(rate_en),
        .restart(rate_restart), .div_next(div_next)
    );

    iso_gate_carrier #(
        .DIV_W(DIV_W)
    ) u_car (
        .clk(clk), .rst_n(rst_n),
        .en(rate_en), .div_q(div_q),
        .restart(rate_restart), .div_next(div_next),
        .phase(carrier_phase), .cnt_o(carrier_cnt)
    );

    iso_gate_lanes #(
        .NUM_OUT(NUM_OUT)
    ) u_lanes (
        .clk(clk), .rst_n(rst_n),
        .en(rate_en), .phase(carrier_phase),
        .user_on(data_q[NUM_OUT-2:0]),
        .drive(gate_drive)
    );
endmodule

// File: rtl/iso_gate_chk.sv
// Module: assertion checker bound to iso_gate_driver.
module iso_gate_chk #(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 4,
    parameter int NUM_OUT = 32,
    parameter int DIV_W   = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_rd,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic               en,
    input logic               restart,
    input logic               phase,
    input logic [DIV_W:0]     cnt,
    input logic [NUM_OUT-1:0] drive
);
    // R3: enable clear means dark outputs on the next edge.
    p_dark_when_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (drive == '0));

    // R2: outside a restart, the phase only flips after the counter hit zero.
    p_flip_at_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase != $past(phase)) && !$past(restart)) |-> ($past(cnt) == '0));

    // R6: a rate write restarts the carrier in the low phase.
    p_restart_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !phase);

    // R4 / R5: a user lane can only be high while the reference lane is high.
    p_ref_covers_user_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (drive[NUM_OUT-2:0] & ~{(NUM_OUT-1){drive[NUM_OUT-1]}}) == '0);

    // R8: rate readback has zero upper bits.
    p_rate_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(iso_gate_pkg::REG_RATE))
            |=> (bus_rdata[DATA_W-1:DIV_W+1] == '0));

    // R7: reset clears the outputs and the read data.
    p_reset_clear_r7: assert property (@(posedge clk)
        !rst_n |=> (drive == '0 && bus_rdata == '0));
endmodule

bind iso_gate_driver iso_gate_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_OUT(NUM_OUT), .DIV_W(DIV_W)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
    .en(rate_en), .restart(rate_restart), .phase(carrier_phase),
    .cnt(carrier_cnt), .drive(gate_drive)
);

// File: tb/tb_iso_gate_driver.sv
module tb_iso_gate_driver;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] gate_drive;

    int cyc = 0;
    int checks = 0;
    int errors = 0;

    typedef struct {
        int          at;
        bit          is_rd;
        logic [31:0] val;
        string       req;
    } item_t;
    item_t sb[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    iso_gate_driver dut (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .gate_drive(gate_drive)
    );

    // Ordered insert into the scoreboard.
    task automatic push_item(input int at, input bit is_rd, input logic [31:0] v, input string req);
        item_t it;
        int k;
        it.at = at; it.is_rd = is_rd; it.val = v; it.req = req;
        k = sb.size();
        while (k > 0 && sb[k-1].at > at) k--;
        sb.insert(k, it);
    endtask

    // Monitor: pop every item due at this cycle and compare.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            checks++;
            act = it.is_rd ? bus_rdata : gate_drive;
            if (it.at != cyc) begin
                errors++;
                $display("FAIL %s stale item for cycle %0d at %0d: actual %h expected %h",
                         it.req, it.at, cyc, act, it.val);
            end else if (act !== it.val) begin
                errors++;
                $display("FAIL %s cycle %0d %s: actual %h expected %h",
                         it.req, cyc, it.is_rd ? "read" : "drive", act, it.val);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One-cycle write; t returns the clock edge at which it takes effect.
    task automatic bus_write(input logic [3:0] a, input logic [31:0] d, output int t);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        t = cyc + 1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // One-cycle read with the expected value due one clock later.
    task automatic bus_read(input logic [3:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        push_item(cyc + 1, 1'b1, exp, req);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // Expected drive from the requirements: lane state at cycle c is the
    // carrier phase at edge c-1, restarted low at edge tr, half-period div+2.
    task automatic expect_wave(input int tr, input int from_c, input int n, input int div,
                               input bit en, input logic [31:0] data, input string req);
        for (int c = from_c; c < from_c + n; c++) begin
            int e;
            bit ph;
            e  = c - 1;
            ph = en && (e >= tr) && ((((e - tr) / (div + 2)) % 2) == 1);
            push_item(c, 1'b0, ph ? {1'b1, data[30:0]} : 32'h0, req);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int t, tr, td;
        idle(3);
        rst_n = 1'b1;

        // R7: reset state of outputs and both registers.
        expect_wave(0, cyc + 1, 6, 0, 1'b0, 32'h0, "R7");
        bus_read(4'd0, 32'h0, "R7");
        bus_read(4'd1, 32'h0, "R7");
        idle(4);

        // R3: data set but enable clear keeps every lane low.
        bus_write(4'd0, 32'h7FFF_FFFF, td);
        expect_wave(0, td + 1, 20, 0, 1'b0, 32'h7FFF_FFFF, "R3");
        idle(20);

        // R2: divisor 0 gives two-clock half periods, all user lanes on.
        bus_write(4'd1, 32'h0000_1000, tr);
        expect_wave(tr, tr + 1, 24, 0, 1'b1, 32'h7FFF_FFFF, "R2");
        idle(24);

        // R4: data change while running keeps carrier timing.
        bus_write(4'd0, 32'h0000_A5A5, td);
        expect_wave(tr, td + 1, 20, 0, 1'b1, 32'h0000_A5A5, "R4");
        idle(20);

        // R6: rate write restarts low with divisor 3.
        bus_write(4'd1, 32'h0000_1003, tr);
        expect_wave(tr, tr + 1, 40, 3, 1'b1, 32'h0000_A5A5, "R6");
        idle(40);

        // R5: only bit 31 in data -> user lanes dark, reference still runs.
        bus_write(4'd0, 32'h8000_0000, td);
        expect_wave(tr, td + 1, 30, 3, 1'b1, 32'h8000_0000, "R5");
        idle(30);
        bus_read(4'd0, 32'h8000_0000, "R1");

        // R8: rate upper bits dropped on readback, divisor 5.
        bus_write(4'd0, 32'h5555_5555, td);
        bus_write(4'd1, 32'hFFFF_F005, tr);
        expect_wave(tr, tr + 1, 50, 5, 1'b1, 32'h5555_5555, "R8");
        idle(50);
        bus_read(4'd1, 32'h0000_1005, "R8");
        bus_read(4'd0, 32'h5555_5555, "R1");

        // R9: unmapped write ignored (carrier and data unchanged), unmapped reads zero.
        expect_wave(tr, cyc + 1, 30, 5, 1'b1, 32'h5555_5555, "R9");
        bus_write(4'd2, 32'hFFFF_FFFF, t);
        bus_read(4'd2, 32'h0, "R9");
        bus_read(4'd15, 32'h0, "R9");
        bus_read(4'd0, 32'h5555_5555, "R9");
        bus_read(4'd1, 32'h0000_1005, "R9");
        idle(24);

        // R10: all-zero rate write stops every lane; data retained.
        bus_write(4'd1, 32'h0, t);
        expect_wave(t, t + 1, 30, 0, 1'b0, 32'h0, "R10");
        idle(30);
        bus_read(4'd0, 32'h5555_5555, "R10");

        // R2: maximum divisor 0xFFF, half period 4097 clocks.
        bus_write(4'd0, 32'h0F0F_0F0F, td);
        bus_write(4'd1, 32'h0000_1FFF, tr);
        expect_wave(tr, tr + 1, 2 * 4097 + 20, 4095, 1'b1, 32'h0F0F_0F0F, "R2");
        idle(2 * 4097 + 20);
        bus_read(4'd0, 32'h0F0F_0F0F, "R1");

        // R7: reset in mid-run clears registers and outputs.
        bus_write(4'd1, 32'h0000_1001, tr);
        idle(9);
        @(negedge clk);
        rst_n = 1'b0;
        expect_wave(0, cyc + 1, 12, 0, 1'b0, 32'h0, "R7");
        idle(2);
        rst_n = 1'b1;
        idle(2);
        bus_read(4'd0, 32'h0, "R7");
        bus_read(4'd1, 32'h0, "R7");
        idle(10);

        if (sb.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard: actual %0d items left expected 0", sb.size());
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule